// File: doc/BRIEF.md
# Signed Multiply-Accumulate Register Unit

This block is a multiply-accumulate datapath for a processor core. It multiplies two 16-bit two's-complement operands and adds the signed product into a 42-bit accumulator. The accumulator is split into a 10-bit upper part and a 32-bit lower part. The instruction decoder and the operand fetch logic sit outside the block. They drive single-cycle commands: clear, accumulate, load one part from a 32-bit bus, and store one part to a 32-bit result bus. The block runs in non-saturating mode only, and addition wraps.

A store returns one part of the accumulator. It also returns condition flags. The zero and negative flags describe the whole 42-bit total, not the 32-bit word that is returned. The upper part is returned sign-extended from 10 bits to 32 bits, so a small negative total reads as all ones in the upper word. A store samples the accumulator as it stands in the cycle of the request. The result and flags appear, registered, in the next cycle.

Top module: `smac_unit`

## Requirements
- R1: After reset the accumulator is zero and `st_vld_o` is low.
- R2: When `mac_vld_i` is high and no clear or load is requested, the signed product of `opa_i` and `opb_i` (both 16-bit two's complement) is added into the accumulator. Example: eight steps of 0x7FFF×0x7FFF from zero give a lower part of 0xFFF80008 and an upper part of 1.
- R3: `clr_i` sets both parts to zero. A following store of either part returns 0 with the zero flag set and the negative flag clear.
- R4: A load with `ld_sel_i`=0 writes all 32 bits of `ld_data_i` into the lower part and leaves the upper part unchanged.
- R5: A load with `ld_sel_i`=1 writes only `ld_data_i[9:0]` into the upper part and leaves the lower part unchanged. Loading 0xA5A5A5A5 reads back as 0x000001A5.
- R6: A store with `st_sel_i`=1 returns the 10-bit upper part sign-extended to 32 bits. A store with `st_sel_i`=0 returns the lower part. After -2×2 from zero, the upper part reads 0xFFFFFFFF and the lower part reads 0xFFFFFFFC.
- R7: The zero flag is 1 only when the full 42-bit total is zero. The negative flag is 1 when bit 41 of the total is set. Both hold for either part.
- R8: The overflow flag is 0 on every store.
- R9: Accumulation wraps modulo 2^42, with no flag. Example: 0x1FF_FFFFFFFF plus 1 gives 0x200_00000000, which reads as upper 0xFFFFFE00 and negative.
- R10: When several commands arrive in one cycle, clear wins over load, and load wins over accumulate.
- R11: A store request in cycle t returns the accumulator value from before any update in cycle t. The result is valid with `st_vld_o` high in cycle t+1.
- R12: With no clear, load or accumulate, the accumulator holds its value, even while the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Clear the accumulator |
| mac_vld_i | input | 1 | Operands valid; accumulate their product |
| opa_i | input | 16 | Multiplicand, two's complement |
| opb_i | input | 16 | Multiplier, two's complement |
| ld_en_i | input | 1 | Load one accumulator part |
| ld_sel_i | input | 1 | Load target: 0 lower, 1 upper |
| ld_data_i | input | 32 | Load data |
| st_req_i | input | 1 | Store request |
| st_sel_i | input | 1 | Store source: 0 lower, 1 upper |
| st_data_o | output | 32 | Stored word |
| st_vld_o | output | 1 | Store result valid |
| flag_z_o | output | 1 | Whole accumulator is zero |
| flag_n_o | output | 1 | Whole accumulator is negative |
| flag_v_o | output | 1 | Overflow (always 0) |

## Verification
The assertions assume the command inputs are known 0/1 values at every clock edge after reset. They also assume a store reports the accumulator as it was in the request cycle. The bench drives every input on the falling edge and holds it for a full cycle, so no command is ever X. The bench's reference model applies clear, load and accumulate in the same priority as the design. It snapshots the total at each store request, so the expected flags come from the 42-bit value and not from the returned word.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_MAC  = 2'd1,
    CMD_LOAD = 2'd2,
    CMD_CLR  = 2'd3
  } smac_cmd_e;
endpackage

// File: rtl/smac_mult.sv
module smac_mult #(
  parameter int OPW  = 16,
  parameter int ACCW = 42
) (
  input  logic [OPW-1:0]  opa_i,
  input  logic [OPW-1:0]  opb_i,
  output logic [ACCW-1:0] prod_o
);
  localparam int PW = 2 * OPW;

  logic signed [PW-1:0] prod_full;

  always_comb begin
    prod_full = $signed(opa_i) * $signed(opb_i);
  end

  // Widen the product to the accumulator width.
  generate
    if (ACCW > PW) begin : g_ext
      assign prod_o = {{(ACCW-PW){prod_full[PW-1]}}, prod_full};
    end else begin : g_trunc
      assign prod_o = prod_full[ACCW-1:0];
    end
  endgenerate
endmodule

// File: rtl/smac_acc.sv
module smac_acc
  import smac_pkg::*;
#(
  parameter int ACCW = 42,
  parameter int LOW_W = 32,
  parameter int BUSW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  smac_cmd_e        cmd_i,
  input  logic             ld_sel_i,
  input  logic [BUSW-1:0]  ld_data_i,
  input  logic [ACCW-1:0]  prod_i,
  output logic [ACCW-1:0]  acc_o
);
  localparam int HI_W = ACCW - LOW_W;

  logic [ACCW-1:0] acc_q;
  logic [ACCW-1:0] acc_d;
  logic            acc_en;

  always_comb begin
    acc_d  = acc_q;
    acc_en = 1'b0;
    unique case (cmd_i)
      CMD_CLR: begin
        acc_d  = '0;
        acc_en = 1'b1;
      end
      CMD_LOAD: begin
        acc_en = 1'b1;
        if (ld_sel_i) begin
          acc_d = {ld_data_i[HI_W-1:0], acc_q[LOW_W-1:0]};
        end else begin
          acc_d = {acc_q[ACCW-1:LOW_W], ld_data_i[LOW_W-1:0]};
        end
      end
      CMD_MAC: begin
        acc_d  = acc_q + prod_i;
        acc_en = 1'b1;
      end
      default: begin
        acc_d  = acc_q;
        acc_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/smac_rdport.sv
module smac_rdport #(
  parameter int ACCW = 42,
  parameter int LOW_W = 32,
  parameter int BUSW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_req_i,
  input  logic            st_sel_i,
  input  logic [ACCW-1:0] acc_i,
  output logic [BUSW-1:0] st_data_o,
  output logic            st_vld_o,
  output logic            flag_z_o,
  output logic            flag_n_o,
  output logic            flag_v_o
);
  localparam int HI_W = ACCW - LOW_W;

  logic [HI_W-1:0]  hi_part;
  logic [LOW_W-1:0] lo_part;
  logic [BUSW-1:0]  data_d, data_q;
  logic             z_d, z_q, n_d, n_q, vld_q;

  assign hi_part = acc_i[ACCW-1:LOW_W];
  assign lo_part = acc_i[LOW_W-1:0];

  always_comb begin
    if (st_sel_i) begin
      data_d = {{(BUSW-HI_W){hi_part[HI_W-1]}}, hi_part};
    end else begin
      data_d = lo_part;
    end
    z_d = (acc_i == '0);
    n_d = acc_i[ACCW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      z_q    <= 1'b0;
      n_q    <= 1'b0;
    end else if (st_req_i) begin
      data_q <= data_d;
      z_q    <= z_d;
      n_q    <= n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= st_req_i;
    end
  end

  assign st_data_o = data_q;
  assign st_vld_o  = vld_q;
  assign flag_z_o  = z_q;
  assign flag_n_o  = n_q;
  assign flag_v_o  = 1'b0;
endmodule

// File: rtl/smac_unit.sv
module smac_unit
  import smac_pkg::*;
#(
  parameter int OPW   = 16,
  parameter int ACCW  = 42,
  parameter int LOW_W = 32,
  parameter int BUSW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            mac_vld_i,
  input  logic [OPW-1:0]  opa_i,
  input  logic [OPW-1:0]  opb_i,
  input  logic            ld_en_i,
  input  logic            ld_sel_i,
  input  logic [BUSW-1:0] ld_data_i,
  input  logic            st_req_i,
  input  logic            st_sel_i,
  output logic [BUSW-1:0] st_data_o,
  output logic            st_vld_o,
  output logic            flag_z_o,
  output logic            flag_n_o,
  output logic            flag_v_o
);
  smac_cmd_e       cmd;
  logic [ACCW-1:0] prod;
  logic [ACCW-1:0] acc_q;

  // Command arbitration: clear, then load, then accumulate.
  always_comb begin
    if (clr_i)          cmd = CMD_CLR;
    else if (ld_en_i)   cmd = CMD_LOAD;
    else if (mac_vld_i) cmd = CMD_MAC;
    else                cmd = CMD_IDLE;
  end

  smac_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .prod_o (prod)
  );

  smac_acc #(.ACCW(ACCW), .LOW_W(LOW_W), .BUSW(BUSW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd),
    .ld_sel_i  (ld_sel_i),
    .ld_data_i (ld_data_i),
    .prod_i    (prod),
    .acc_o     (acc_q)
  );

  smac_rdport #(.ACCW(ACCW), .LOW_W(LOW_W), .BUSW(BUSW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_req_i  (st_req_i),
    .st_sel_i  (st_sel_i),
    .acc_i     (acc_q),
    .st_data_o (st_data_o),
    .st_vld_o  (st_vld_o),
    .flag_z_o  (flag_z_o),
    .flag_n_o  (flag_n_o),
    .flag_v_o  (flag_v_o)
  );
endmodule

// File: rtl/smac_chk.sv
module smac_chk #(
  parameter int ACCW  = 42,
  parameter int LOW_W = 32,
  parameter int BUSW  = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_i,
  input logic            mac_vld_i,
  input logic            ld_en_i,
  input logic            ld_sel_i,
  input logic [BUSW-1:0] ld_data_i,
  input logic            st_req_i,
  input logic            st_sel_i,
  input logic [ACCW-1:0] acc_q,
  input logic [BUSW-1:0] st_data_o,
  input logic            st_vld_o,
  input logic            flag_z_o,
  input logic            flag_n_o,
  input logic            flag_v_o
);
  localparam int HI_W = ACCW - LOW_W;

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));

  // R5
  load_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && ld_en_i && ld_sel_i) |=>
      (acc_q[ACCW-1:LOW_W] == $past(ld_data_i[HI_W-1:0])) &&
      (acc_q[LOW_W-1:0] == $past(acc_q[LOW_W-1:0])));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld_o |-> !flag_v_o);

  // R11
  store_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_req_i |=> st_vld_o);

  // R7
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_req_i |=> (flag_n_o == $past(acc_q[ACCW-1])));

  // R6
  hi_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req_i && st_sel_i) |=>
      ($countones(st_data_o[BUSW-1:HI_W-1]) == 0 ||
       $countones(st_data_o[BUSW-1:HI_W-1]) == BUSW-HI_W+1));

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !ld_en_i && !mac_vld_i) |=> $stable(acc_q));
endmodule

bind smac_unit smac_chk #(.ACCW(ACCW), .LOW_W(LOW_W), .BUSW(BUSW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_i     (clr_i),
  .mac_vld_i (mac_vld_i),
  .ld_en_i   (ld_en_i),
  .ld_sel_i  (ld_sel_i),
  .ld_data_i (ld_data_i),
  .st_req_i  (st_req_i),
  .st_sel_i  (st_sel_i),
  .acc_q     (acc_q),
  .st_data_o (st_data_o),
  .st_vld_o  (st_vld_o),
  .flag_z_o  (flag_z_o),
  .flag_n_o  (flag_n_o),
  .flag_v_o  (flag_v_o)
);

// File: tb/sim_smac_unit.sv
module sim_smac_unit;
  logic        clk, rst_n;
  logic        clr_i, mac_vld_i, ld_en_i, ld_sel_i, st_req_i, st_sel_i;
  logic [15:0] opa_i, opb_i;
  logic [31:0] ld_data_i;
  logic [31:0] st_data_o;
  logic        st_vld_o, flag_z_o, flag_n_o, flag_v_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] data;
    logic        z;
    logic        n;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [41:0] model;

  smac_unit u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .mac_vld_i(mac_vld_i),
    .opa_i(opa_i), .opb_i(opb_i), .ld_en_i(ld_en_i), .ld_sel_i(ld_sel_i),
    .ld_data_i(ld_data_i), .st_req_i(st_req_i), .st_sel_i(st_sel_i),
    .st_data_o(st_data_o), .st_vld_o(st_vld_o), .flag_z_o(flag_z_o),
    .flag_n_o(flag_n_o), .flag_v_o(flag_v_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pops an expected item for each valid store result.
  always @(negedge clk) begin
    if (rst_n && st_vld_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11", "unexpected store result", {32'd0, st_data_o}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(st_data_o == e.data, e.req, "data", {32'd0, st_data_o}, {32'd0, e.data});
        check(flag_z_o == e.z, "R7", "zero flag", {63'd0, flag_z_o}, {63'd0, e.z});
        check(flag_n_o == e.n, "R7", "neg flag", {63'd0, flag_n_o}, {63'd0, e.n});
        check(flag_v_o == 1'b0, "R8", "overflow flag", {63'd0, flag_v_o}, 64'd0);
      end
    end
  end

  task automatic idle_in();
    clr_i = 0; mac_vld_i = 0; ld_en_i = 0; ld_sel_i = 0;
    st_req_i = 0; st_sel_i = 0;
  endtask

  // One cycle with any mix of commands; model applies the same priority.
  task automatic cycle(input bit c, input bit l, input bit lsel, input logic [31:0] ld,
                       input bit m, input logic [15:0] a, input logic [15:0] b,
                       input bit st, input bit ssel, input string req);
    logic signed [41:0] p;
    exp_t e;
    @(negedge clk);
    clr_i = c; ld_en_i = l; ld_sel_i = lsel; ld_data_i = ld;
    mac_vld_i = m; opa_i = a; opb_i = b; st_req_i = st; st_sel_i = ssel;
    if (st) begin
      e.data = ssel ? {{22{model[41]}}, model[41:32]} : model[31:0];
      e.z = (model == 42'd0);
      e.n = model[41];
      e.req = req;
      sb.push_back(e);
    end
    if (c) model = '0;
    else if (l) begin
      if (lsel) model[41:32] = ld[9:0];
      else model[31:0] = ld;
    end else if (m) begin
      p = $signed(a) * $signed(b);
      model = model + p;
    end
  endtask

  task automatic store(input bit sel, input string req);
    cycle(0, 0, 0, 32'h0, 0, 16'h0, 16'h0, 1, sel, req);
  endtask
  task automatic mac(input logic [15:0] a, input logic [15:0] b);
    cycle(0, 0, 0, 32'h0, 1, a, b, 0, 0, "");
  endtask
  task automatic load(input bit sel, input logic [31:0] d);
    cycle(0, 1, sel, d, 0, 16'h0, 16'h0, 0, 0, "");
  endtask
  task automatic clear();
    cycle(1, 0, 0, 32'h0, 0, 16'h0, 16'h0, 0, 0, "");
  endtask

  initial begin
    #200000;
    check(1'b0, "WATCHDOG", "timeout", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_in(); opa_i = 0; opb_i = 0; ld_data_i = 0;
    model = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: idle outputs in reset
    check(st_vld_o == 1'b0, "R1", "valid in reset", {63'd0, st_vld_o}, 64'd0);
    rst_n = 1;
    // R1: accumulator zero after reset
    store(0, "R1"); store(1, "R1");
    // R3: clear after loads
    load(0, 32'hA5A5A5A5); load(1, 32'hA5A5A5A5);
    // R4, R5: load readback
    store(0, "R4"); store(1, "R5");
    clear();
    store(0, "R3"); store(1, "R3");
    // R2: 2*2
    mac(16'd2, 16'd2); store(0, "R2"); store(1, "R2");
    // R6: -2*2 from zero
    clear(); mac(16'hFFFE, 16'd2); store(0, "R6"); store(1, "R6");
    // R2: eight steps of 0x7FFF^2
    clear();
    for (int i = 0; i < 8; i++) mac(16'h7FFF, 16'h7FFF);
    store(0, "R2"); store(1, "R2");
    // R2: most-negative operands
    mac(16'h8000, 16'h8000); mac(16'h8000, 16'h7FFF); store(0, "R2"); store(1, "R2");
    // R12: idle cycles with changing operands
    for (int i = 0; i < 4; i++)
      cycle(0, 0, 0, 32'hFFFF0000, 0, 16'(i * 977), 16'h1234, 0, 0, "");
    store(0, "R12"); store(1, "R12");
    // R9: wrap past the positive limit, then to zero
    load(1, 32'h000001FF); load(0, 32'hFFFFFFFF);
    mac(16'd1, 16'd1); store(1, "R9"); store(0, "R9");
    load(1, 32'h000003FF); load(0, 32'hFFFFFFFF);
    mac(16'd1, 16'd1); store(0, "R9");
    // R4: low load keeps high part
    load(1, 32'h00000155); load(0, 32'h00000000); store(1, "R4"); store(0, "R4");
    // R7: zero low word but nonzero total
    store(0, "R7");
    // R10: clear beats load and accumulate
    cycle(1, 1, 0, 32'h12345678, 1, 16'd5, 16'd5, 0, 0, "");
    store(0, "R10");
    // R10: load beats accumulate
    cycle(0, 1, 0, 32'h00000010, 1, 16'd7, 16'd7, 0, 0, "");
    store(0, "R10");
    // R11: store sees value before same-cycle update
    cycle(0, 0, 0, 32'h0, 1, 16'd3, 16'd3, 1, 0, "R11");
    store(0, "R11");
    cycle(1, 0, 0, 32'h0, 0, 16'd0, 16'd0, 1, 1, "R11");
    store(1, "R11");
    @(negedge clk); idle_in();
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R11", "pending results", 64'(sb.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule